// File: doc/BRIEF.md
# Pixel Column Counter/Shift Chain with Configuration Latches

This block models one column of a hybrid pixel detector's digital matrix. Each cell holds a 14-bit register. During acquisition the register counts hits. During readout or configuration it becomes one segment of a single serial chain that runs through the whole column. Bits enter at cell 0 and move toward the last cell, one position per enabled read-clock cycle. The last bit of the last cell drives the column's serial output, which a chip-level collector would take in.

Each cell also owns an 8-bit configuration latch. To load the matrix, a controller streams a full column of bits into the chain. It then pulses a load strobe, and every cell copies the low eight bits of its register into its latch at once. The latch drives a mask bit, a test-pulse enable, a four-bit threshold trim and a two-bit operating mode. The mask bit also stops the cell's counter. The counter saturates so that it cannot wrap. Shifting always takes priority over counting, so a readout can never be corrupted by late hits.

Top module: `pixcol_chain`

## Requirements
- R1: After reset every counter register is zero, `ser_out` is 0, and every cell's configuration is mask=1, test=0, threshold trim=0, mode=0.
- R2: On each clock with `shift_en` high, every cell register moves one place toward its MSB. Bit 13 of cell k enters bit 0 of cell k+1, and `ser_in` enters bit 0 of cell 0. `ser_out` is always bit 13 of the last cell.
- R3: A bit stream pushed through `ser_in` appears at `ser_out` unchanged and in the same order after NPIX*14 (3584) enabled shifts.
- R4: While `shift_en` and `cnt_en` are both low, no register changes. Stall cycles inserted in a stream therefore do not alter it.
- R5: With `cnt_en` high and `shift_en` low, an unmasked cell whose `hit` bit is high increments by one on each clock.
- R6: When `shift_en` is high, counting is suppressed in every cell, whatever `cnt_en` and `hit` are.
- R7: A cell whose configured mask bit is 1 ignores its `hit` input.
- R8: A counter at 16383 (all ones) stays there on further hits.
- R9: A `cfg_load` pulse makes each cell latch bits [7:0] of its own register, and the outputs change on the clock that samples the strobe. The field layout is: bit 0 mask, bit 1 test enable, bits 5:2 threshold trim, bit 6 mode bit 0, bit 7 mode bit 1.
- R10: Without `cfg_load`, configuration outputs keep their value, including while the chain shifts.
- R11: During readout the last cell's register leaves first, MSB first, followed by the next lower cell. A chain bit at position p = cell*14 + bit is seen at `ser_out` before shift number NPIX*14-1-p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read/count clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Acquisition window; enables counting |
| hit | input | NPIX | Per-cell hit pulses (bit k for cell k) |
| shift_en | input | 1 | Read-clock enable; shifts the chain by one |
| ser_in | input | 1 | Serial data into cell 0 |
| cfg_load | input | 1 | Strobe: all cells latch their low 8 register bits |
| ser_out | output | 1 | Serial data from bit 13 of the last cell |
| cfg_mask | output | NPIX | Latched mask bit per cell |
| cfg_test | output | NPIX | Latched test-pulse enable per cell |
| cfg_thr | output | 4*NPIX | Latched threshold trim, cell k at [4k+3:4k] |
| cfg_mode | output | 2*NPIX | Latched mode bits, cell k at [2k+1:2k] |

## Verification
Every result here is one register stage away from its cause. A shift, an increment or a configuration capture is visible right after the clock edge that samples the control. The bench drives inputs and samples outputs on falling edges. Before each shift it reads `ser_out`, which holds the bit that the previous rising edge placed at the chain's end, so readout bit j is compared just before shift j. Configuration fields are read one falling edge after the strobe, and counter values are read back through a full readout after the hit window closes.

// File: rtl/pixcol_pkg.sv
package pixcol_pkg;
    localparam int CNT_W = 14;
    localparam int CFG_W = 8;

    // Field order is behaviour: the latch copies register bits [7:0] in this layout
    typedef struct packed {
        logic [1:0] mode;   // bit 7 = mode[1], bit 6 = mode[0]
        logic [3:0] thr;    // bits 5:2
        logic       test;   // bit 1
        logic       mask;   // bit 0
    } cfg_t;

    localparam cfg_t CFG_RST = '{mode: 2'b00, thr: 4'h0, test: 1'b0, mask: 1'b1};
endpackage

// File: rtl/pix_cell.sv
module pix_cell #(
    parameter int CNT_W = pixcol_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             cnt_en,
    input  logic             hit,
    input  logic             mask,
    input  logic             chain_in,
    output logic [CNT_W-1:0] reg_q
);
    typedef struct packed {
        logic [CNT_W-1:0] bits;
    } cell_s;

    cell_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.bits = {st_q.bits[CNT_W-2:0], chain_in};
        end else if (cnt_en && hit && !mask && !(&st_q.bits)) begin
            st_d.bits = st_q.bits + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_q = st_q.bits;
endmodule

// File: rtl/pix_cfg_latch.sv
module pix_cfg_latch
    import pixcol_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] src,
    output cfg_t             cfg_q
);
    typedef struct packed {
        cfg_t word;
    } latch_s;

    latch_s lt_d, lt_q;

    always_comb begin
        lt_d = lt_q;
        if (load) lt_d.word = cfg_t'(src);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lt_q <= '{word: CFG_RST};
        else        lt_q <= lt_d;
    end

    assign cfg_q = lt_q.word;
endmodule

// File: rtl/pixcol_chain.sv
module pixcol_chain #(
    parameter int NPIX  = 256,
    parameter int CNT_W = pixcol_pkg::CNT_W,
    parameter int CFG_W = pixcol_pkg::CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [NPIX-1:0]   hit,
    input  logic              shift_en,
    input  logic              ser_in,
    input  logic              cfg_load,
    output logic              ser_out,
    output logic [NPIX-1:0]   cfg_mask,
    output logic [NPIX-1:0]   cfg_test,
    output logic [4*NPIX-1:0] cfg_thr,
    output logic [2*NPIX-1:0] cfg_mode
);
    import pixcol_pkg::*;

    localparam int CHAIN_LEN = NPIX * CNT_W;

    logic [CHAIN_LEN-1:0] chain_q;
    cfg_t                 cfg_w [NPIX];

    for (genvar k = 0; k < NPIX; k++) begin : g_cell
        logic link_in;
        if (k == 0) begin : g_head
            assign link_in = ser_in;
        end else begin : g_body
            assign link_in = chain_q[k*CNT_W-1];
        end

        pix_cell #(.CNT_W(CNT_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .cnt_en   (cnt_en),
            .hit      (hit[k]),
            .mask     (cfg_w[k].mask),
            .chain_in (link_in),
            .reg_q    (chain_q[k*CNT_W +: CNT_W])
        );

        pix_cfg_latch u_cfg (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (cfg_load),
            .src   (chain_q[k*CNT_W +: CFG_W]),
            .cfg_q (cfg_w[k])
        );

        assign cfg_mask[k]          = cfg_w[k].mask;
        assign cfg_test[k]          = cfg_w[k].test;
        assign cfg_thr[4*k +: 4]    = cfg_w[k].thr;
        assign cfg_mode[2*k +: 2]   = cfg_w[k].mode;
    end

    assign ser_out = chain_q[CHAIN_LEN-1];
endmodule

// File: rtl/pixcol_chain_chk.sv
module pixcol_chain_chk #(
    parameter int NPIX  = 256,
    parameter int CNT_W = 14,
    parameter int CFG_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cnt_en,
    input logic [NPIX-1:0]       hit,
    input logic                  shift_en,
    input logic                  ser_in,
    input logic                  cfg_load,
    input logic [NPIX*CNT_W-1:0] chain_q,
    input logic [NPIX-1:0]       cfg_mask,
    input logic [NPIX-1:0]       cfg_test,
    input logic [4*NPIX-1:0]     cfg_thr,
    input logic [2*NPIX-1:0]     cfg_mode
);
    localparam int L = NPIX * CNT_W;

    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> chain_q == {$past(chain_q[L-2:0]), $past(ser_in)}); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !cnt_en) |=> $stable(chain_q)); // R4

    AST_HEAD_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && cnt_en && hit[0] && !cfg_mask[0] && !(&chain_q[CNT_W-1:0]))
        |=> chain_q[CNT_W-1:0] == $past(chain_q[CNT_W-1:0]) + CNT_W'(1)); // R5

    AST_MASKED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && cfg_mask[0]) |=> $stable(chain_q[CNT_W-1:0])); // R7

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && (&chain_q[CNT_W-1:0])) |=> (&chain_q[CNT_W-1:0])); // R8

    AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> {cfg_mode[1:0], cfg_thr[3:0], cfg_test[0], cfg_mask[0]}
                     == $past(chain_q[CFG_W-1:0])); // R9

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ($stable(cfg_mask) && $stable(cfg_test)
                       && $stable(cfg_thr) && $stable(cfg_mode))); // R10
endmodule

bind pixcol_chain pixcol_chain_chk #(.NPIX(NPIX), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .hit      (hit),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .cfg_load (cfg_load),
    .chain_q  (chain_q),
    .cfg_mask (cfg_mask),
    .cfg_test (cfg_test),
    .cfg_thr  (cfg_thr),
    .cfg_mode (cfg_mode)
);

// File: tb/sim_pixcol_chain.sv
module sim_pixcol_chain;
    localparam int CLK_P = 10;
    localparam int NPIX  = 256;
    localparam int CW    = 14;
    localparam int L     = NPIX * CW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cnt_en = 1'b0;
    logic [NPIX-1:0]   hit = '0;
    logic              shift_en = 1'b0;
    logic              ser_in = 1'b0;
    logic              cfg_load = 1'b0;
    logic              ser_out;
    logic [NPIX-1:0]   cfg_mask;
    logic [NPIX-1:0]   cfg_test;
    logic [4*NPIX-1:0] cfg_thr;
    logic [2*NPIX-1:0] cfg_mode;

    int checks = 0;
    int errors = 0;
    logic stream [L];
    logic [CW-1:0] cnt_exp [NPIX];

    always #(CLK_P/2) clk = ~clk;

    pixcol_chain #(.NPIX(NPIX)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .hit(hit),
        .shift_en(shift_en), .ser_in(ser_in), .cfg_load(cfg_load),
        .ser_out(ser_out), .cfg_mask(cfg_mask), .cfg_test(cfg_test),
        .cfg_thr(cfg_thr), .cfg_mode(cfg_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [7:0] cfg_word(input int k);
        logic [7:0] t;
        t = 8'(k * 29 + 11);
        return {t[7:1], (k % 3 == 0)};
    endfunction

    // Push stream[0..L-1] in; stall_every>0 inserts idle cycles (R4)
    task automatic push_stream(input int stall_every);
        for (int i = 0; i < L; i++) begin
            if (stall_every > 0 && i % stall_every == 5) begin
                shift_en = 1'b0;
                @(negedge clk);
            end
            ser_in   = stream[i];
            shift_en = 1'b1;
            @(negedge clk);
        end
        shift_en = 1'b0;
        ser_in   = 1'b0;
    endtask

    // Read L bits out, compare with stream[j] before shift j, zeros enter
    task automatic read_compare(input string req);
        for (int j = 0; j < L; j++) begin
            chk(ser_out == stream[j], req, int'(ser_out), int'(stream[j]));
            ser_in   = 1'b0;
            shift_en = 1'b1;
            @(negedge clk);
        end
        shift_en = 1'b0;
    endtask

    // R11: readout bit j comes from position p = L-1-j
    task automatic stream_from_counts();
        for (int j = 0; j < L; j++) begin
            int p;
            p = L - 1 - j;
            stream[j] = cnt_exp[p / CW][p % CW];
        end
    endtask

    task automatic test_reset();
        chk(ser_out == 1'b0, "R1 ser_out", int'(ser_out), 0);
        chk(cfg_mask == '1, "R1 mask", $countones(cfg_mask), NPIX);
        chk(cfg_test == '0, "R1 test", $countones(cfg_test), 0);
        chk(cfg_thr == '0, "R1 thr", $countones(cfg_thr), 0);
        chk(cfg_mode == '0, "R1 mode", $countones(cfg_mode), 0);
        for (int j = 0; j < L; j++) stream[j] = 1'b0;
        read_compare("R1 counters zero");
    endtask

    task automatic test_stream();
        for (int i = 0; i < L; i++) stream[i] = logic'(((i * 5 + i / 7) % 3) == 1);
        push_stream(97);
        chk(cfg_mask == '1, "R10 mask kept during shift", $countones(cfg_mask), NPIX);
        chk(cfg_thr == '0, "R10 thr kept during shift", $countones(cfg_thr), 0);
        read_compare("R3 R2 R4 stream order");
    endtask

    task automatic test_config();
        for (int i = 0; i < L; i++) begin
            int p;
            logic [7:0] w;
            p = L - 1 - i;
            w = cfg_word(p / CW);
            stream[i] = (p % CW < 8) ? w[p % CW] : 1'b0;
        end
        push_stream(0);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        for (int k = 0; k < NPIX; k++) begin
            logic [7:0] w;
            logic [7:0] got;
            w = cfg_word(k);
            got = {cfg_mode[2*k +: 2], cfg_thr[4*k +: 4], cfg_test[k], cfg_mask[k]};
            chk(got == w, "R9 cfg fields", int'(got), int'(w));
        end
        // R6: read back with counting requested on every cell
        cnt_en = 1'b1;
        hit    = '1;
        read_compare("R6 shift over count");
        cnt_en = 1'b0;
        hit    = '0;
        for (int k = 0; k < NPIX; k += 51) begin
            logic [7:0] w;
            logic [7:0] got;
            w = cfg_word(k);
            got = {cfg_mode[2*k +: 2], cfg_thr[4*k +: 4], cfg_test[k], cfg_mask[k]};
            chk(got == w, "R10 cfg kept", int'(got), int'(w));
        end
    endtask

    task automatic test_count();
        for (int k = 0; k < NPIX; k++) cnt_exp[k] = '0;
        cnt_en = 1'b1;
        for (int c = 0; c < 40; c++) begin
            hit[1]   = (c < 10);
            hit[2]   = (c < 25);
            hit[3]   = 1'b1;
            hit[254] = (c < 7);
            @(negedge clk);
        end
        hit = '0;
        cnt_en = 1'b0;
        @(negedge clk);
        cnt_exp[1]   = 14'd10;  // R5
        cnt_exp[2]   = 14'd25;  // R5
        cnt_exp[3]   = 14'd0;   // R7 cell 3 masked
        cnt_exp[254] = 14'd7;   // R5
        stream_from_counts();
        read_compare("R5 R7 R11 count readout");
    endtask

    task automatic test_saturate();
        for (int k = 0; k < NPIX; k++) cnt_exp[k] = '0;
        cnt_en = 1'b1;
        hit[1] = 1'b1;
        repeat (16400) @(negedge clk);
        hit = '0;
        cnt_en = 1'b0;
        @(negedge clk);
        cnt_exp[1] = '1;
        stream_from_counts();
        read_compare("R8 saturation");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_stream();
        test_config();
        test_count();
        test_saturate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule